// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Pair

This unit performs 32-bit integer multiplication and division over many clock cycles and keeps its results in two private result registers, HI and LO, rather than in a general register. A multiply leaves the full 64-bit product across the pair, with the upper word in HI and the lower word in LO. A divide leaves the quotient in LO and the remainder in HI. Signed and unsigned forms of both operations are supported.

A single-cycle `start` pulse launches an operation. The unit first takes the magnitudes of the operands. It then runs 32 iteration cycles, using shift-and-add for a multiply and restoring subtraction for a divide. A final cycle restores the signs and writes HI and LO. A requester reads HI or LO through one move-from port. While an operation is running, `busy` is high and any read request is stalled.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, `busy` is low, `mf_stall` is low, and both HI and LO read as zero.
- R2: Operation code 2'b00 (signed multiply) writes the 64-bit two's-complement product of `opa` and `opb` to HI (bits 63:32) and LO (bits 31:0).
- R3: Operation code 2'b01 (unsigned multiply) writes the 64-bit unsigned product to HI (upper word) and LO (lower word).
- R4: Operation code 2'b11 (unsigned divide) writes `opa / opb` to LO and `opa % opb` to HI.
- R5: Operation code 2'b10 (signed divide) truncates the quotient toward zero. The remainder carries the sign of the dividend. The case 0x80000000 / 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R6: Division by zero, signed or unsigned, leaves LO = 0xFFFFFFFF and HI equal to the unmodified dividend `opa`.
- R7: Timing of an accepted start:
  - `busy` goes high on the clock edge that accepts the start and stays high for exactly 33 cycles.
  - HI and LO keep their previous values until the last of those cycles.
  - The new results can be read in the first cycle that `busy` is low.
- R8: The read port returns HI when `mf_sel` = 1 and LO when `mf_sel` = 0, combinationally.
- R9: While `busy` is high, a read request (`mf_req` = 1) raises `mf_stall`, and `mf_data` reads zero.
- R10: A `start` pulse that arrives while `busy` is high is ignored. The running operation finishes with its original operands and operation code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches an operation when the unit is idle |
| op | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa | input | 32 | Multiplicand or dividend |
| opb | input | 32 | Multiplier or divisor |
| busy | output | 1 | High while an operation is running |
| mf_req | input | 1 | Read request for HI or LO |
| mf_sel | input | 1 | 1 selects HI, 0 selects LO |
| mf_data | output | 32 | Selected result word; zero while stalled |
| mf_stall | output | 1 | Read request held off because the unit is busy |

## Verification
The start is driven on a falling edge and accepted on the next rising edge. `busy` is expected high at the falling edge that follows, and the bench confirms that it stays high at each of the next 32 falling edges. At the 34th falling edge after the start it must be low, and HI and LO are read there through the combinational read port. Stall behaviour is probed while a divide is running. A second start is injected in the middle of an operation, and the bench confirms that the final HI/LO values belong to the first operation.

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  input  logic         mf_req,
  input  logic         mf_sel,
  output logic [W-1:0] mf_data,
  output logic         mf_stall
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  hi_q, lo_q, w_hi, w_lo, m_b, a_raw;
  logic [CW-1:0] cnt;
  logic          fix, is_div, neg_main, neg_rem, dz;

  wire         sgn   = ~op[0];
  wire         a_neg = sgn & opa[W-1];
  wire         b_neg = sgn & opb[W-1];
  wire [W-1:0] a_mag = a_neg ? -opa : opa;
  wire [W-1:0] b_mag = b_neg ? -opb : opb;

  wire [W:0]   m_sum = {1'b0, w_hi} + (w_lo[0] ? {1'b0, m_b} : '0);
  wire [W:0]   d_try = {w_hi, w_lo[W-1]};
  wire         d_ge  = d_try >= {1'b0, m_b};
  wire [W:0]   d_dif = d_try - {1'b0, m_b};

  wire [2*W-1:0] prod  = {w_hi, w_lo};
  wire [2*W-1:0] prodf = neg_main ? -prod : prod;
  wire [W-1:0]   quof  = neg_main ? -w_lo : w_lo;
  wire [W-1:0]   remf  = neg_rem  ? -w_hi : w_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; fix <= 1'b0; cnt <= '0;
      hi_q <= '0; lo_q <= '0; w_hi <= '0; w_lo <= '0; m_b <= '0; a_raw <= '0;
      is_div <= 1'b0; neg_main <= 1'b0; neg_rem <= 1'b0; dz <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        fix      <= 1'b0;
        cnt      <= '0;
        is_div   <= op[1];
        neg_main <= a_neg ^ b_neg;
        neg_rem  <= a_neg;
        dz       <= op[1] & (opb == '0);
        a_raw    <= opa;
        w_hi     <= '0;
        w_lo     <= a_mag;
        m_b      <= b_mag;
      end
    end else if (!fix) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) fix <= 1'b1;
      if (is_div) begin
        w_hi <= d_ge ? d_dif[W-1:0] : d_try[W-1:0];
        w_lo <= {w_lo[W-2:0], d_ge};
      end else begin
        w_hi <= m_sum[W:1];
        w_lo <= {m_sum[0], w_lo[W-1:1]};
      end
    end else begin
      busy <= 1'b0;
      fix  <= 1'b0;
      if (!is_div) begin
        hi_q <= prodf[2*W-1:W];
        lo_q <= prodf[W-1:0];
      end else if (dz) begin
        hi_q <= a_raw;
        lo_q <= '1;
      end else begin
        hi_q <= remf;
        lo_q <= quof;
      end
    end
  end

  assign mf_stall = mf_req & busy;
  assign mf_data  = mf_stall ? '0 : (mf_sel ? hi_q : lo_q);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fix |=> busy && $stable(hi_q) && $stable(lo_q));
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    busy && fix |=> !busy);
  a_r10_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(m_b) && $stable(is_div) && $stable(a_raw));
  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    mf_req && busy |-> mf_stall && mf_data == '0);
  a_r6_divzero: assert property (@(posedge clk) disable iff (!rst_n)
    busy && fix && is_div && dz |=> lo_q == '1 && hi_q == $past(a_raw));
endmodule

// File: tb/muldiv_hilo_tb.sv
module muldiv_hilo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  localparam logic [65:0] VECS [NV] = '{
    {2'd0, 32'd7,         32'hFFFFFFFD},
    {2'd0, 32'h80000000,  32'h80000000},
    {2'd0, 32'hFFFFFFFF,  32'hFFFFFFFF},
    {2'd1, 32'hFFFFFFFF,  32'hFFFFFFFF},
    {2'd1, 32'h12345678,  32'h9ABCDEF0},
    {2'd3, 32'd100,       32'd7},
    {2'd3, 32'hFFFFFFFF,  32'd10},
    {2'd3, 32'd3,         32'd9},
    {2'd2, 32'hFFFFFFF9,  32'd2},
    {2'd2, 32'd7,         32'hFFFFFFFE},
    {2'd2, 32'h80000000,  32'hFFFFFFFF},
    {2'd3, 32'd5,         32'd0},
    {2'd2, 32'hFFFFFFF7,  32'd0}
  };

  logic clk = 0, rst_n = 0, start = 0, mf_req = 0, mf_sel = 0;
  logic [1:0] op = 0;
  logic [31:0] opa = 0, opb = 0;
  logic busy, mf_stall;
  logic [31:0] mf_data;
  int n_chk = 0, n_bad = 0;

  muldiv_hilo u_dut (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa),
    .opb(opb), .busy(busy), .mf_req(mf_req), .mf_sel(mf_sel), .mf_data(mf_data),
    .mf_stall(mf_stall));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] sa, sb, q, r;
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    case (o)
      2'd0: return sa * sb;
      2'd1: return {32'd0, a} * {32'd0, b};
      2'd3: return (b == 0) ? {a, 32'hFFFFFFFF} : {a % b, a / b};
      default: begin
        if (b == 0) return {a, 32'hFFFFFFFF};
        q = sa / sb;
        r = sa % sb;
        return {r[31:0], q[31:0]};
      end
    endcase
  endfunction

  task automatic read_hilo(output logic [31:0] h, output logic [31:0] l);
    mf_req = 1; mf_sel = 1; #1 h = mf_data;
    mf_sel = 0; #1 l = mf_data;
    mf_req = 0;
  endtask

  task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                        input bit poke, input string tag);
    logic [63:0] e;
    logic [31:0] h, l;
    bit stayed;
    e = model(o, a, b);
    @(negedge clk); start = 1; op = o; opa = a; opb = b;
    @(negedge clk); start = 0;
    chk(busy === 1'b1, "R7 busy after start", {31'd0, busy}, 32'd1);
    stayed = 1;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      stayed &= (busy === 1'b1);
      if (poke && i == 5) begin
        start = 1; op = ~o; opa = ~a; opb = 32'd3;
        mf_req = 1; mf_sel = 1; #1;
        chk(mf_stall === 1'b1 && mf_data === 32'd0, "R9 stall while busy", mf_data, 32'd0);
        mf_req = 0;
      end
      if (poke && i == 6) start = 0;
    end
    chk(stayed, "R7 busy held 33 cycles", 32'd0, 32'd1);
    @(negedge clk);
    chk(busy === 1'b0, "R7 busy low after 33", {31'd0, busy}, 32'd0);
    read_hilo(h, l);
    chk(h === e[63:32], {tag, " HI (R8 sel=1)"}, h, e[63:32]);
    chk(l === e[31:0],  {tag, " LO (R8 sel=0)"}, l, e[31:0]);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] h, l;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    read_hilo(h, l);
    chk(busy === 1'b0 && h === 0 && l === 0, "R1 reset state", h | l, 32'd0);
    mf_req = 1; #1;
    chk(mf_stall === 1'b0, "R1 no stall when idle", {31'd0, mf_stall}, 32'd0);
    mf_req = 0;
    for (int v = 0; v < NV; v++) begin
      logic [1:0] o;
      logic [31:0] a, b;
      string tg;
      o = VECS[v][65:64]; a = VECS[v][63:32]; b = VECS[v][31:0];
      if (o[1] && b == 0) tg = "R6";
      else tg = (o == 0) ? "R2" : (o == 1) ? "R3" : (o == 3) ? "R4" : "R5";
      run_op(o, a, b, 1'b0, tg);
    end
    run_op(2'd3, 32'd1000, 32'd33, 1'b1, "R10 start ignored while busy, R4");
    run_op(2'd0, 32'hFFFF0000, 32'd12345, 1'b1, "R10 start ignored while busy, R2");
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule